// File: doc/BRIEF.md
# Background Tile Fetch Pipeline

This block drives the repeating eight-cycle memory fetch sequence that a tiled video generator uses to build its background. From a 15-bit scroll address it forms, in fixed order, the address of the tile's name byte, the address of the attribute byte that selects its palette, and the addresses of the two pattern planes that hold the tile's bitmap. It captures each returned byte and, once a tile is complete, emits eight 4-bit pixel codes together with the index of the tile they belong to.

After every tile the scroll address steps one tile to the right. Past the right edge of a nametable the step wraps into the neighbouring one. On the last visible tile of a line it instead steps one pixel row down, with a wrap at row 29 into the next nametable. An external dot counter paces the block. Fetches run on dots 1 to 256 and again on dots 321 to 340, and the two tiles fetched in that second window are the first two tiles of the following line. A load port lets the surrounding logic overwrite the scroll address, for example to copy scroll bits between lines.

Top module: `bgf_fetch_pipe`

## Requirements
- R1: After reset `v_out` is 0, `pix_valid` is 0 and `pix_codes` is 0.
- R2: On fetch slot 0, where the slot is `(dot-1) mod 8`, the block asserts `mem_rd` with address `{2'b10, v[11:0]}`. The byte returned on slot 1 is kept as the tile number.
- R3: On slot 2 the address is `{2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]}`. The byte returned on slot 3 is shifted right by `{v[6], v[1], 1'b0}`, and its low two bits become the palette of the tile.
- R4: On slot 4 the address is `{1'b0, pat_base_sel, tile[7:0], 1'b0, v[14:12]}`. On slot 6 it is the same address with bit 3 set. The bytes returned on slots 5 and 7 are the low and high planes.
- R5: In the cycle after slot 7, `pix_valid` is 1 for one cycle. Pixel i (i=0 leftmost) sits in `pix_codes[4i+3:4i]` as `{palette, high[7-i], low[7-i]}`, and it is forced to 0 when both plane bits are 0.
- R6: Memory data is taken one cycle after its address. `mem_rd` is high exactly on even slots of dots 1–256 and 321–340 while `render_en` is 1, and it is low on all other dots.
- R7: After slot 7 (other than on dot 256): if `v[4:0]` is 31, it becomes 0 and `v[10]` inverts; otherwise `v` increases by 1.
- R8: After slot 7 on dot 256, the step is vertical. If `v[14:12] < 7`, it increments. Otherwise it clears, and `v[9:5]` steps: 29 goes to 0 with `v[11]` inverted, 31 goes to 0 with no inversion, and any other value increments.
- R9: `pix_tile` is `(dot-328)/8` for tiles completed after dot 320 (so 0 or 1), and `dot/8+1` for tiles completed on dots 8–256 (so 2 to 33).
- R10: While `render_en` is 0 the block issues no read, captures no byte, emits no pixels and holds `v`.
- R11: When `v_load` is 1, `v` takes `v_load_val` on the next edge, and this overrides any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Rendering enable; 0 stalls the pipeline |
| dot | input | 9 | Horizontal dot counter, 0 to 340 |
| pat_base_sel | input | 1 | Pattern table half select (address bit 12) |
| v_load | input | 1 | Overwrite the scroll address |
| v_load_val | input | 15 | Value for `v_load` |
| v_out | output | 15 | Current scroll address |
| mem_rd | output | 1 | Read strobe for the video memory |
| mem_addr | output | 14 | Read address, zero when `mem_rd` is 0 |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| pix_valid | output | 1 | One-cycle strobe for a finished tile |
| pix_tile | output | 6 | Tile index of the finished tile on the line |
| pix_codes | output | 32 | Eight 4-bit pixel codes, pixel 0 in the low nibble |

## Verification
A wrong scroll address shows up at once on `v_out`, and one fetch slot later as a wrong `mem_addr` on the next name or attribute read. A mistaken step at a wrap therefore surfaces within a cycle of the tile boundary. A stale tile number or palette is invisible until the pattern-plane address two to four cycles later, or until the codes of that tile come out after slot 7. The bench compares every port on every clock against a behavioural model, so a slip in slot order or data latency fails within the same tile.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int VW    = 15;          // scroll address width
  localparam int AW    = 14;          // video memory address width
  localparam int DW    = 8;           // memory data width
  localparam int NPIX  = 8;           // pixels per tile
  localparam int CODEW = 4;           // pixel code width
  localparam int DOTW  = 9;           // dot counter width
  localparam int TILEW = 6;           // tile index width
  localparam int SLOTW = $clog2(NPIX);

  typedef logic [VW-1:0] vaddr_t;
  typedef logic [AW-1:0] maddr_t;

  // name byte: page 2, low 12 scroll bits
  function automatic maddr_t name_addr(input vaddr_t v);
    return {2'b10, v[11:0]};
  endfunction

  // attribute byte: table at the end of the selected page
  function automatic maddr_t attr_addr(input vaddr_t v);
    return {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]};
  endfunction

  // right-shift selecting the 2-bit palette of the 16x16 quadrant
  function automatic logic [2:0] attr_shift(input vaddr_t v);
    return {v[6], v[1], 1'b0};
  endfunction

  function automatic maddr_t pat_addr(input logic base_sel, input logic [DW-1:0] tile,
                                      input logic plane, input logic [2:0] fine_y);
    return {1'b0, base_sel, tile, plane, fine_y};
  endfunction

  function automatic vaddr_t step_horiz(input vaddr_t v);
    if (v[4:0] == 5'd31) return {v[14:11], ~v[10], v[9:5], 5'd0};
    return v + vaddr_t'(1);
  endfunction

  function automatic vaddr_t step_vert(input vaddr_t v);
    vaddr_t r;
    r = v;
    if (v[14:12] != 3'd7) begin
      r[14:12] = v[14:12] + 3'd1;
    end else begin
      r[14:12] = 3'd0;
      if (v[9:5] == 5'd29) begin
        r[9:5] = 5'd0;
        r[11]  = ~v[11];
      end else if (v[9:5] == 5'd31) begin
        r[9:5] = 5'd0;
      end else begin
        r[9:5] = v[9:5] + 5'd1;
      end
    end
    return r;
  endfunction

  function automatic logic [CODEW-1:0] px_code(input logic [1:0] pal, input logic hi,
                                               input logic lo);
    return ({hi, lo} == 2'b00) ? '0 : {pal, hi, lo};
  endfunction
endpackage

// File: rtl/bgf_slot_decode.sv
module bgf_slot_decode
  import bgf_pkg::*;
#(
  parameter int FETCH_LAST = 256,
  parameter int PRE_FIRST  = 321,
  parameter int LINE_LAST  = 340
) (
  input  logic              render_en,
  input  logic [DOTW-1:0]   dot,
  output logic [SLOTW-1:0]  slot,
  output logic              active,
  output logic              line_end,
  output logic [TILEW-1:0]  tile_now
);
  localparam int PRE_BASE = PRE_FIRST + 2*NPIX - 1 - NPIX;   // dot of first prefetched tile end
  logic [DOTW-1:0] dm1;
  logic [DOTW-1:0] t_full;
  logic            in_win;

  assign dm1    = dot - DOTW'(1);
  assign slot   = dm1[SLOTW-1:0];
  assign in_win = ((dot >= DOTW'(1)) && (dot <= DOTW'(FETCH_LAST))) ||
                  ((dot >= DOTW'(PRE_FIRST)) && (dot <= DOTW'(LINE_LAST)));
  assign active   = render_en && in_win;
  assign line_end = (dot == DOTW'(FETCH_LAST));
  assign t_full   = (dot > DOTW'(FETCH_LAST)) ? ((dot - DOTW'(PRE_BASE)) >> SLOTW)
                                              : ((dot >> SLOTW) + DOTW'(1));
  assign tile_now = t_full[TILEW-1:0];
endmodule

// File: rtl/bgf_scroll_reg.sv
module bgf_scroll_reg
  import bgf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  vaddr_t load_val,
  input  logic   step_h,
  input  logic   step_v,
  output vaddr_t v_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      v_q <= '0;
    else if (load)   v_q <= load_val;
    else if (step_v) v_q <= step_vert(v_q);
    else if (step_h) v_q <= step_horiz(v_q);
  end

  a_r7_coarse_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step_h && !load && (v_q[4:0] == 5'd31) |=> (v_q[4:0] == 5'd0) && (v_q[10] != $past(v_q[10])));
  a_r8_fine_y_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_v && !load && (v_q[14:12] != 3'd7) |=>
      (v_q[14:12] == ($past(v_q[14:12]) + 3'd1)) && (v_q[11:0] == $past(v_q[11:0])));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_h && !step_v && !load |=> $stable(v_q));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (v_q == $past(load_val)));
endmodule

// File: rtl/bgf_pixel_pack.sv
module bgf_pixel_pack
  import bgf_pkg::*;
(
  input  logic [1:0]            pal,
  input  logic [DW-1:0]         lo,
  input  logic [DW-1:0]         hi,
  output logic [NPIX*CODEW-1:0] codes
);
  for (genvar i = 0; i < NPIX; i++) begin : g_px
    assign codes[i*CODEW +: CODEW] = px_code(pal, hi[NPIX-1-i], lo[NPIX-1-i]);
  end
endmodule

// File: rtl/bgf_fetch_pipe.sv
module bgf_fetch_pipe
  import bgf_pkg::*;
#(
  parameter int FETCH_LAST = 256,
  parameter int PRE_FIRST  = 321,
  parameter int LINE_LAST  = 340
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  render_en,
  input  logic [DOTW-1:0]       dot,
  input  logic                  pat_base_sel,
  input  logic                  v_load,
  input  logic [VW-1:0]         v_load_val,
  output logic [VW-1:0]         v_out,
  output logic                  mem_rd,
  output logic [AW-1:0]         mem_addr,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  pix_valid,
  output logic [TILEW-1:0]      pix_tile,
  output logic [NPIX*CODEW-1:0] pix_codes
);
  localparam logic [SLOTW-1:0] S_NAME = SLOTW'(0);
  localparam logic [SLOTW-1:0] S_ATTR = SLOTW'(2);
  localparam logic [SLOTW-1:0] S_LOW  = SLOTW'(4);
  localparam logic [SLOTW-1:0] S_HIGH = SLOTW'(6);
  localparam logic [SLOTW-1:0] S_LAST = SLOTW'(NPIX-1);

  logic [SLOTW-1:0] slot;
  logic             active, line_end;
  logic [TILEW-1:0] tile_now;
  vaddr_t           v_q;
  logic [DW-1:0]    name_q, low_q;
  logic [1:0]       pal_q;
  logic [NPIX*CODEW-1:0] codes_now;
  // named events for the checks
  logic tile_done, step_h, step_v;

  bgf_slot_decode #(.FETCH_LAST(FETCH_LAST), .PRE_FIRST(PRE_FIRST), .LINE_LAST(LINE_LAST))
    u_dec (.render_en(render_en), .dot(dot), .slot(slot), .active(active),
           .line_end(line_end), .tile_now(tile_now));

  assign tile_done = active && (slot == S_LAST);
  assign step_v    = tile_done && line_end;
  assign step_h    = tile_done && !line_end;

  bgf_scroll_reg u_scroll (.clk(clk), .rst_n(rst_n), .load(v_load), .load_val(v_load_val),
                           .step_h(step_h), .step_v(step_v), .v_q(v_q));
  assign v_out = v_q;

  assign mem_rd = active && !slot[0];
  always_comb begin
    mem_addr = '0;
    if (mem_rd) begin
      unique case (slot)
        S_NAME:  mem_addr = name_addr(v_q);
        S_ATTR:  mem_addr = attr_addr(v_q);
        S_LOW:   mem_addr = pat_addr(pat_base_sel, name_q, 1'b0, v_q[14:12]);
        S_HIGH:  mem_addr = pat_addr(pat_base_sel, name_q, 1'b1, v_q[14:12]);
        default: mem_addr = '0;
      endcase
    end
  end

  bgf_pixel_pack u_pack (.pal(pal_q), .lo(low_q), .hi(mem_rdata), .codes(codes_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      name_q    <= '0;
      pal_q     <= '0;
      low_q     <= '0;
      pix_valid <= 1'b0;
      pix_tile  <= '0;
      pix_codes <= '0;
    end else begin
      pix_valid <= tile_done;
      if (active) begin
        case (slot)
          SLOTW'(1): name_q <= mem_rdata;
          SLOTW'(3): pal_q  <= 2'(mem_rdata >> attr_shift(v_q));
          SLOTW'(5): low_q  <= mem_rdata;
          S_LAST: begin
            pix_codes <= codes_now;
            pix_tile  <= tile_now;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_name_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && (slot == S_NAME) |-> (mem_addr[13:12] == 2'b10));
  a_r6_no_read_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |-> !mem_rd);
  a_r5_valid_after_tile: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> pix_valid);
  a_r5_valid_only_after_tile: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(tile_done));
  a_r10_no_output_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |=> !pix_valid);
  for (genvar i = 0; i < NPIX; i++) begin : g_chk
    a_r5_transparent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && (pix_codes[i*CODEW +: 2] == 2'b00) |-> (pix_codes[i*CODEW+2 +: 2] == 2'b00));
  end
endmodule

// File: tb/sim_bgf_fetch_pipe.sv
`timescale 1ns/1ps
module sim_bgf_fetch_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        render_en = 1'b0;
  logic [8:0]  dot = '0;
  logic        pat_base_sel = 1'b0;
  logic        v_load = 1'b0;
  logic [14:0] v_load_val = '0;
  logic [14:0] v_out;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        pix_valid;
  logic [5:0]  pix_tile;
  logic [31:0] pix_codes;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int    mv = 0, mnm = 0, mat = 0, mlo = 0, ecodes = 0, etile = 0;
  bit    epv = 0;
  int    paddr = 0;
  string vtag = "R1";

  always #4 clk = ~clk;

  bgf_fetch_pipe u0 (.clk(clk), .rst_n(rst_n), .render_en(render_en), .dot(dot),
    .pat_base_sel(pat_base_sel), .v_load(v_load), .v_load_val(v_load_val), .v_out(v_out),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_tile(pix_tile), .pix_codes(pix_codes));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int memf(input int a);
    if ((a & 'h30) == 'h30) return 0;
    return ((a * 13) ^ (a >> 3) ^ 'h5A) & 'hFF;
  endfunction

  task automatic cyc(input int d, input bit en, input bit ld, input int lv);
    int sl, rd, ea, sh, b, c;
    bit act;
    @(negedge clk);
    chk(int'(v_out) == mv, vtag, int'(v_out), mv);
    chk(pix_valid == epv, en ? "R5" : "R10", int'(pix_valid), int'(epv));
    if (epv && pix_valid) begin
      chk(int'(pix_codes) == ecodes, "R5 R3", int'(pix_codes), ecodes);
      chk(int'(pix_tile) == etile, "R9", int'(pix_tile), etile);
    end
    rd = memf(paddr);
    dot = 9'(d); render_en = en; v_load = ld; v_load_val = 15'(lv); mem_rdata = 8'(rd);
    #1;
    sl  = (d - 1) & 7;
    act = en && (((d >= 1) && (d <= 256)) || ((d >= 321) && (d <= 340)));
    chk(mem_rd == (act && (sl % 2 == 0)), en ? "R6" : "R10", int'(mem_rd),
        int'(act && (sl % 2 == 0)));
    if (act && (sl % 2 == 0)) begin
      if (sl == 0) begin
        ea = 'h2000 | (mv & 'hFFF);
        chk(int'(mem_addr) == ea, "R2", int'(mem_addr), ea);
      end else if (sl == 2) begin
        ea = 'h23C0 | (mv & 'hC00) | ((mv >> 4) & 'h38) | ((mv >> 2) & 7);
        chk(int'(mem_addr) == ea, "R3", int'(mem_addr), ea);
      end else begin
        ea = (pat_base_sel ? 'h1000 : 0) | (mnm << 4) | ((mv >> 12) & 7) | (sl == 6 ? 8 : 0);
        chk(int'(mem_addr) == ea, "R4", int'(mem_addr), ea);
      end
    end
    paddr = int'(mem_addr);
    epv = 0;
    vtag = act ? "R7" : "R10";
    if (act) begin
      case (sl)
        1: mnm = rd;
        3: begin sh = ((mv >> 4) & 4) | (mv & 2); mat = (rd >> sh) & 3; end
        5: mlo = rd;
        7: begin
          ecodes = 0;
          for (int i = 0; i < 8; i++) begin
            b = ((rd >> (7 - i)) & 1) * 2 + ((mlo >> (7 - i)) & 1);
            c = (b == 0) ? 0 : mat * 4 + b;
            ecodes = ecodes | (c << (4 * i));
          end
          epv = 1;
          etile = (d > 320) ? (d - 328) / 8 : d / 8 + 1;
          if (d == 256) begin
            int fy, cy;
            vtag = "R8";
            fy = (mv >> 12) & 7;
            cy = (mv >> 5) & 31;
            if (fy < 7) mv = mv + 'h1000;
            else begin
              mv = mv & 'h0FFF;
              if (cy == 29) mv = (mv & ~('h1F << 5)) ^ 'h800;
              else if (cy == 31) mv = mv & ~('h1F << 5);
              else mv = mv + 'h20;
            end
          end else begin
            if ((mv & 31) == 31) mv = (mv & ~31) ^ 'h400;
            else mv = mv + 1;
          end
        end
        default: ;
      endcase
    end
    if (ld) begin mv = lv & 'h7FFF; vtag = "R11"; end
  endtask

  task automatic run_line(input bit ld0, input int lv0, input int stall_at, input int mid_ld_at,
                          input int mid_lv, input bit en);
    for (int d = 0; d <= 340; d++) begin
      if (d == stall_at) for (int k = 0; k < 5; k++) cyc(d, 1'b0, 1'b0, 0);
      cyc(d, en, (ld0 && d == 0) || (d == mid_ld_at), (d == mid_ld_at) ? mid_lv : lv0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(v_out == '0, "R1", int'(v_out), 0);
    chk(pix_valid == 1'b0, "R1", int'(pix_valid), 0);
    chk(pix_codes == '0, "R1", int'(pix_codes), 0);
    // coarse X near wrap, fine Y 7, coarse Y 29: R7 wrap and R8 row-29 wrap
    run_line(1, (7 << 12) | (29 << 5) | 30, -1, -1, 0, 1);
    // coarse Y 31 with fine Y 7, upper pattern half
    pat_base_sel = 1'b1;
    run_line(1, (7 << 12) | (31 << 5) | 5 | 'h400, -1, -1, 0, 1);
    // plain line continuing from previous state with a mid-tile stall
    pat_base_sel = 1'b0;
    run_line(0, 0, 101, -1, 0, 1);
    // load landing on a tile-end slot overrides the increment
    run_line(0, 0, -1, 16, 'h2ABC, 1);
    // whole line with rendering disabled
    run_line(0, 0, -1, -1, 0, 0);
    run_line(1, (3 << 12) | (12 << 5) | 31 | 'h800, -1, -1, 0, 1);
    @(negedge clk);
    chk(int'(v_out) == mv, vtag, int'(v_out), mv);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule